// File: doc/BRIEF.md
# Signed Add/Subtract Unit with Decimal Readout

This block adds or subtracts two 3-bit two's-complement operands and widens the answer to a 4-bit signed value, so a result that leaves the 3-bit range is still exact. A mode input selects the operation. In subtract mode the first operand is taken away from the second. The adder inverts the first operand bit by bit and injects a carry of one. An overflow flag reports when the 3-bit sum cannot hold the true value. When that happens the flag supplies the missing fourth bit.

The 4-bit result goes out unchanged on a set of indicator LEDs. It is also shown in signed decimal on a four-position seven-segment display that is scanned one position at a time. The rightmost position shows the magnitude, a digit from 0 to 8. The position to its left shows a minus sign when the result is negative. The remaining positions stay dark. Segment lines and position enables are active low. A clock and an asynchronous active-low reset drive only the scan. The arithmetic path is purely combinational.

Top module: `signed_addsub_display`

## Requirements
- R1: With `sub_mode` = 0, `led` equals opb + opa as a 4-bit two's-complement value, for every operand pair.
- R2: With `sub_mode` = 1, `led` equals opb − opa as a 4-bit two's-complement value, for every operand pair, including opa = −4.
- R3: `ovf` is 1 exactly when the true signed result lies outside −4..3, that is, when both effective operands share a sign and the 3-bit sum has the other sign.
- R4: `ovf` always equals the XOR of the carry into and the carry out of the operand sign bit.
- R5: While position 0 is enabled, `seg_n` shows the result magnitude (0..8) as an active-low pattern in bit order {g,f,e,d,c,b,a}. The lit segments are: 0 abcdef, 1 bc, 2 abdeg, 3 abcdg, 4 bcfg, 5 acdfg, 6 acdefg, 7 abc, 8 all seven.
- R6: While position 1 is enabled, `seg_n` is 7'b0111111 (only g lit, a minus) when the result is negative, and 7'b1111111 (dark) otherwise. A zero result therefore shows no minus.
- R7: While position 2 or 3 is enabled, `seg_n` is 7'b1111111.
- R8: Exactly one `dig_n` bit is low at a time. Reset enables position 0. Each position stays enabled for HOLD clock cycles (16 by default), then the next position in the order 0, 1, 2, 3 is enabled, and the order wraps back to 0. After n rising edges following reset release, position (n / HOLD) mod 4 is enabled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Scan clock |
| rst_n | input | 1 | Asynchronous active-low reset of the scan |
| opa | input | 3 | First operand, two's complement |
| opb | input | 3 | Second operand, two's complement |
| sub_mode | input | 1 | 0: opb + opa, 1: opb − opa |
| led | output | 4 | Signed 4-bit result |
| ovf | output | 1 | 3-bit overflow indicator |
| seg_n | output | 7 | Active-low segments {g,f,e,d,c,b,a} |
| dig_n | output | 4 | Active-low position enables, bit i = position i |

## Verification
On every cycle, the assertions check four things. The overflow flag must match the sign-bit carry pair. The displayed magnitude must never exceed eight. A zero result must never light a minus, and a negative result must always light one on position 1. Each scan position must hold for its count and then move on. The arithmetic values can only be shown by the bench's scenarios. The bench sweeps all 128 combinations of operands and mode, and for each one runs a full scan rotation. It compares the result, the flag and every enabled position's segment pattern against signed arithmetic done in the bench.

// File: rtl/addsub_pkg.sv
package addsub_pkg;

    localparam logic [6:0] SEG_BLANK = 7'b1111111;
    localparam logic [6:0] SEG_MINUS = 7'b0111111;

    // Active-low glyph for a decimal value 0..8, bit order {g,f,e,d,c,b,a}
    function automatic logic [6:0] seg_glyph(input logic [3:0] val);
        logic [6:0] lit;
        case (val)
            4'd0:    lit = 7'b0111111;
            4'd1:    lit = 7'b0000110;
            4'd2:    lit = 7'b1011011;
            4'd3:    lit = 7'b1001111;
            4'd4:    lit = 7'b1100110;
            4'd5:    lit = 7'b1101101;
            4'd6:    lit = 7'b1111101;
            4'd7:    lit = 7'b0000111;
            4'd8:    lit = 7'b1111111;
            default: lit = 7'b0000000;
        endcase
        return ~lit;
    endfunction

endpackage

// File: rtl/addsub_core.sv
module addsub_core #(
    parameter int W = 3
) (
    input  logic [W-1:0] op_a,
    input  logic [W-1:0] op_b,
    input  logic         sub,
    output logic [W:0]   res,
    output logic         ovf
);

    logic [W-1:0] a_eff;
    logic [W-1:0] sum;
    logic [W:0]   carry;

    assign a_eff    = op_a ^ {W{sub}};
    assign carry[0] = sub;

    for (genvar i = 0; i < W; i++) begin : g_bit
        assign sum[i]     = a_eff[i] ^ op_b[i] ^ carry[i];
        assign carry[i+1] = (a_eff[i] & op_b[i]) | (carry[i] & (a_eff[i] ^ op_b[i]));
    end

    // Sign rule: like-signed effective operands giving an opposite-signed sum
    assign ovf = (a_eff[W-1] == op_b[W-1]) && (sum[W-1] != op_b[W-1]);
    // The overflow supplies the true sign in the extra bit
    assign res = {sum[W-1] ^ ovf, sum};

    always_comb begin
        assert_ovf_carry_R4: assert (ovf == (carry[W] ^ carry[W-1]))
            else $error("overflow disagrees with sign-bit carries");
    end

endmodule

// File: rtl/scan_ctrl.sv
module scan_ctrl #(
    parameter int DIGITS = 4,
    parameter int HOLD   = 16
) (
    input  logic                        clk,
    input  logic                        rst_n,
    output logic [$clog2(DIGITS)-1:0]   idx,
    output logic [DIGITS-1:0]           dig_n
);

    localparam int IW = $clog2(DIGITS);
    localparam int CW = (HOLD > 1) ? $clog2(HOLD) : 1;

    typedef struct packed {
        logic [CW-1:0] cnt;
        logic [IW-1:0] idx;
    } scan_t;

    scan_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (st_q.cnt == CW'(HOLD - 1)) begin
            st_d.cnt = '0;
            st_d.idx = (st_q.idx == IW'(DIGITS - 1)) ? '0 : st_q.idx + 1'b1;
        end else begin
            st_d.cnt = st_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign idx = st_q.idx;

    always_comb begin
        for (int i = 0; i < DIGITS; i++) begin
            dig_n[i] = !(st_q.idx == IW'(i));
        end
    end

    assert_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.cnt != CW'(HOLD - 1)) |=> $stable(dig_n))
        else $error("position changed before its hold count");

    assert_advance_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.cnt == CW'(HOLD - 1)) |=> !$stable(dig_n))
        else $error("position did not advance after its hold count");

endmodule

// File: rtl/digit_decode.sv
module digit_decode
    import addsub_pkg::*;
#(
    parameter int W      = 3,
    parameter int DIGITS = 4
) (
    input  logic [W:0]                res,
    input  logic [$clog2(DIGITS)-1:0] idx,
    output logic [6:0]                seg_n
);

    localparam int IW = $clog2(DIGITS);

    logic       neg;
    logic [W:0] mag;

    assign neg = res[W];
    assign mag = neg ? (~res + 1'b1) : res;

    always_comb begin
        if (idx == IW'(0))      seg_n = seg_glyph(4'(mag));
        else if (idx == IW'(1)) seg_n = neg ? SEG_MINUS : SEG_BLANK;
        else                    seg_n = SEG_BLANK;
    end

    always_comb begin
        assert_mag_range_R5: assert (mag <= (W+1)'(1 << W))
            else $error("magnitude above one decimal digit");
    end

endmodule

// File: rtl/signed_addsub_display.sv
module signed_addsub_display
    import addsub_pkg::*;
#(
    parameter int W      = 3,
    parameter int DIGITS = 4,
    parameter int HOLD   = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [W-1:0]      opa,
    input  logic [W-1:0]      opb,
    input  logic              sub_mode,
    output logic [W:0]        led,
    output logic              ovf,
    output logic [6:0]        seg_n,
    output logic [DIGITS-1:0] dig_n
);

    localparam int IW = $clog2(DIGITS);

    logic [W:0]    res;
    logic [IW-1:0] scan_idx;

    addsub_core #(.W(W)) u_core (
        .op_a (opa),
        .op_b (opb),
        .sub  (sub_mode),
        .res  (res),
        .ovf  (ovf)
    );

    scan_ctrl #(.DIGITS(DIGITS), .HOLD(HOLD)) u_scan (
        .clk   (clk),
        .rst_n (rst_n),
        .idx   (scan_idx),
        .dig_n (dig_n)
    );

    digit_decode #(.W(W), .DIGITS(DIGITS)) u_decode (
        .res   (res),
        .idx   (scan_idx),
        .seg_n (seg_n)
    );

    assign led = res;

    assert_zero_no_minus_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (led == '0 && !dig_n[1]) |-> seg_n == SEG_BLANK)
        else $error("zero result lit a minus");

    assert_neg_minus_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (led[W] && !dig_n[1]) |-> seg_n == SEG_MINUS)
        else $error("negative result without minus");

endmodule

// File: tb/test_signed_addsub_display.sv
`timescale 1ns/1ps
module test_signed_addsub_display;

    localparam int W    = 3;
    localparam int DIG  = 4;
    localparam int HOLD = 16;

    logic         clk;
    logic         rst_n;
    logic [W-1:0] opa, opb;
    logic         sub_mode;
    logic [W:0]   led;
    logic         ovf;
    logic [6:0]   seg_n;
    logic [DIG-1:0] dig_n;

    int n_chk  = 0;
    int n_fail = 0;
    int edges  = 0;
    bit done   = 0;

    signed_addsub_display #(.W(W), .DIGITS(DIG), .HOLD(HOLD)) i_signed_addsub_display (
        .clk(clk), .rst_n(rst_n), .opa(opa), .opb(opb), .sub_mode(sub_mode),
        .led(led), .ovf(ovf), .seg_n(seg_n), .dig_n(dig_n)
    );

    initial clk = 1'b0;
    always #4 clk = ~clk;

    function automatic logic [6:0] exp_glyph(input int v);
        case (v)
            0: return ~7'h3F;
            1: return ~7'h06;
            2: return ~7'h5B;
            3: return ~7'h4F;
            4: return ~7'h66;
            5: return ~7'h6D;
            6: return ~7'h7D;
            7: return ~7'h07;
            8: return ~7'h7F;
            default: return 7'h00;
        endcase
    endfunction

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d (opa=%0d opb=%0d sub=%0b)",
                     req, act, exp, opa, opb, sub_mode);
        end
    endtask

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    endtask

    initial begin
        #(8 * 200000);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog expired");
            summary();
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0; opa = '0; opb = '0; sub_mode = 1'b0;
        repeat (3) @(negedge clk);
        // R8: reset enables position 0
        check(dig_n == 4'b1110, "R8 reset position", int'(dig_n), 14);
        rst_n = 1'b1;

        for (int s = 0; s < 2; s++) begin
            for (int ai = -4; ai < 4; ai++) begin
                for (int bi = -4; bi < 4; bi++) begin
                    int exp_v, mag, pos;
                    bit exp_ovf;
                    logic [6:0] exp_seg;
                    sub_mode = s[0];
                    opa = ai[W-1:0];
                    opb = bi[W-1:0];
                    #1;
                    exp_v   = (s == 1) ? bi - ai : bi + ai;
                    exp_ovf = (exp_v > 3) || (exp_v < -4);
                    if (s == 0)
                        check(led == exp_v[W:0], "R1 sum", int'(led), exp_v & 15);
                    else
                        check(led == exp_v[W:0], "R2 difference", int'(led), exp_v & 15);
                    check(ovf == exp_ovf, "R3 overflow", int'(ovf), int'(exp_ovf));
                    mag = (exp_v < 0) ? -exp_v : exp_v;

                    repeat (DIG * HOLD) begin
                        @(posedge clk);
                        edges++;
                        @(negedge clk);
                        pos = (edges / HOLD) % DIG;
                        check(dig_n == ~(4'b0001 << pos), "R8 scan position",
                              int'(dig_n), int'(~(4'b0001 << pos)) & 15);
                        if (pos == 0) begin
                            exp_seg = exp_glyph(mag);
                            check(seg_n == exp_seg, "R5 magnitude glyph", int'(seg_n), int'(exp_seg));
                        end else if (pos == 1) begin
                            exp_seg = (exp_v < 0) ? 7'b0111111 : 7'b1111111;
                            check(seg_n == exp_seg, "R6 sign position", int'(seg_n), int'(exp_seg));
                        end else begin
                            check(seg_n == 7'b1111111, "R7 unused position dark", int'(seg_n), 127);
                        end
                    end
                end
            end
        end

        done = 1;
        summary();
        $finish;
    end

endmodule